// File: doc/BRIEF.md
# Auto-Reload Timer Channel Bank

This block holds a bank of down-counting timer channels (five by default), each 32 bits wide. Every channel has a count buffer that software loads ahead of time, plus a live counter. All channels except the last also have a compare buffer. One shared control register holds a group of bits for each channel. The block does not act on the level of these bits. It acts when a write over the register bus changes a bit: a rise of the manual-update bit copies the buffer into the counter, a rise of the start bit sets the counter running, and a fall of the start bit halts it.

Each channel has its own tick input, driven by an external prescaler. A running channel counts down by one on each tick. A tick that finds the counter at zero is an expiry. On expiry the channel raises a one-cycle pulse. If its auto-reload bit is set, it then reloads from the count buffer and keeps running. If not, it stops and the hardware clears that channel's start bit in the control register. The live count of every channel can be read back at its observation address.

Top module: `reload_tmr_bank`

## Requirements
- R1: After reset, the control register, every buffer and every counter read 0, and `expire_o` is 0.
- R2: Addresses are byte offsets. Control is at 0x08. Channel n (n < 4) has its count buffer at 0x0C+0xC·n, its compare buffer 4 above that and its observation register 8 above that. Channel 4 has its count buffer at 0x3C and its observation register at 0x40, and has no compare buffer. Buffers read back the value last written.
- R3: When a control write takes a channel's manual-update bit from 0 to 1, the counter is loaded from that channel's count buffer. A write that leaves the bit at 1 does not load the counter.
- R4: A 0→1 change of a channel's start bit sets it running. A running channel counts down by one on each cycle in which its `tick_i` bit is high. A stopped channel ignores ticks.
- R5: A 1→0 change of the start bit halts the channel, and its count holds.
- R6: A tick that reaches a running channel whose counter is at 0 is an expiry. The channel's `expire_o` bit is high for exactly the next cycle.
- R7: On expiry with auto-reload set, the counter is reloaded from the count buffer and the start bit stays set.
- R8: On expiry without auto-reload, the counter stays at 0, the channel stops, and its start bit reads back as 0.
- R9: Channel 0's control bits start at bit 0. Channel n ≥ 1 starts at bit 4n+4. Within each group the order is start, manual update, output invert, auto-reload. The last channel has no invert bit, and its auto-reload bit is bit 22.
- R10: A tick arriving in the same cycle as a control-register write has no effect on the counter.
- R11: Reads of unmapped addresses (including 0x00) return 0. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| tick_i | input | 5 | Per-channel count tick from the prescaler |
| expire_o | output | 5 | Per-channel one-cycle expiry pulse |

## Verification
The hardest case to reach is the expiry of the irregularly laid-out last channel, first with auto-reload and then without it. The bench gets there by loading the channel's buffer with 1 and writing a control word with its manual-update bit and start bit set at bits 20 to 22. It then applies single ticks until the pulse appears. Finally it reads the control register back to see whether bit 20 was cleared by hardware. A tick driven in the very cycle of a control write is also set up on purpose, to show that the count does not move.

// File: rtl/reload_tmr_pkg.sv
package reload_tmr_pkg;

  typedef enum logic [2:0] {RK_NONE, RK_CTL, RK_BUF, RK_CMP, RK_OBS} rkind_e;

  localparam int CTL_ADDR = 8;
  localparam int BUF_BASE = 12;
  localparam int STRIDE   = 12;

  // first bit of channel n's control group
  function automatic int grp_base(int n);
    return (n == 0) ? 0 : 4 * n + 4;
  endfunction

  function automatic int start_pos(int n);
    return grp_base(n);
  endfunction

  function automatic int man_pos(int n);
    return grp_base(n) + 1;
  endfunction

  // the last channel lacks the invert bit, so reload moves down one place
  function automatic int reload_pos(int n, int nch);
    return (n == nch - 1) ? grp_base(n) + 2 : grp_base(n) + 3;
  endfunction

  function automatic int buf_addr(int n);
    return BUF_BASE + STRIDE * n;
  endfunction

  function automatic int obs_addr(int n, int nch);
    return (n == nch - 1) ? buf_addr(n) + 4 : buf_addr(n) + 8;
  endfunction

  function automatic logic [31:0] count_down(logic [31:0] c);
    return c - 32'd1;
  endfunction

endpackage

// File: rtl/reload_tmr_decode.sv
module reload_tmr_decode
  import reload_tmr_pkg::*;
#(
  parameter int NCH = 5,
  parameter int AW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0]  addr_i,
  output rkind_e         kind_o,
  output logic [CHW-1:0] ch_o
);

  always_comb begin
    kind_o = RK_NONE;
    ch_o   = '0;
    if (addr_i == AW'(CTL_ADDR)) kind_o = RK_CTL;
    for (int n = 0; n < NCH; n++) begin
      if (addr_i == AW'(buf_addr(n))) begin
        kind_o = RK_BUF;
        ch_o   = CHW'(n);
      end
      if (addr_i == AW'(obs_addr(n, NCH))) begin
        kind_o = RK_OBS;
        ch_o   = CHW'(n);
      end
      if (n < NCH - 1 && addr_i == AW'(buf_addr(n) + 4)) begin
        kind_o = RK_CMP;
        ch_o   = CHW'(n);
      end
    end
  end

endmodule

// File: rtl/reload_tmr_chan.sv
module reload_tmr_chan
  import reload_tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          ctl_wr_i,
  input  logic          man_old_i,
  input  logic          man_new_i,
  input  logic          run_i,
  input  logic          ar_i,
  input  logic          buf_wr_i,
  input  logic          cmp_wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] buf_o,
  output logic [CW-1:0] cmp_o,
  output logic          expire_o,
  output logic          stop_o
);

  logic [CW-1:0] cnt_q, buf_q, cmp_q;
  logic          exp_q;
  logic          man_rise;   // manual-update edge seen in this write
  logic          step;       // tick accepted this cycle
  logic          fire;       // expiry event this cycle

  assign man_rise = ctl_wr_i & man_new_i & ~man_old_i;
  assign step     = ~ctl_wr_i & run_i & tick_i;
  assign fire     = step & (cnt_q == '0);
  assign stop_o   = fire & ~ar_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      buf_q <= '0;
      cmp_q <= '0;
      exp_q <= 1'b0;
    end else begin
      if (buf_wr_i) buf_q <= wdata_i;
      if (cmp_wr_i) cmp_q <= wdata_i;
      if (man_rise)      cnt_q <= buf_q;
      else if (fire)     cnt_q <= ar_i ? buf_q : cnt_q;
      else if (step)     cnt_q <= CW'(count_down(32'(cnt_q)));
      exp_q <= fire;
    end
  end

  assign cnt_o    = cnt_q;
  assign buf_o    = buf_q;
  assign cmp_o    = cmp_q;
  assign expire_o = exp_q;

  p_manual_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(man_rise) |-> cnt_q == $past(buf_q));
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step && cnt_q != '0) |-> cnt_q == $past(cnt_q) - CW'(1));
  p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_i && !man_rise) |-> cnt_q == $past(cnt_q));
  p_expire_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> $past(run_i && tick_i && !ctl_wr_i && cnt_q == '0));
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && $past(ar_i)) |-> cnt_q == $past(buf_q));
  p_self_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !$past(ar_i)) |-> (!run_i && cnt_q == '0));
  p_write_blocks_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_wr_i && !man_rise) |-> cnt_q == $past(cnt_q));

endmodule

// File: rtl/reload_tmr_bank.sv
module reload_tmr_bank
  import reload_tmr_pkg::*;
#(
  parameter int NCH = 5,
  parameter int AW  = 8,
  parameter int CW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [31:0]    rd_data,
  input  logic [NCH-1:0] tick_i,
  output logic [NCH-1:0] expire_o
);

  rkind_e         w_kind, r_kind;
  logic [CHW-1:0] w_ch, r_ch;
  logic [31:0]    ctl_q, ctl_nxt;
  logic           ctl_wr;
  logic [NCH-1:0] stop_req;
  logic [CW-1:0]  cnt_a [NCH];
  logic [CW-1:0]  buf_a [NCH];
  logic [CW-1:0]  cmp_a [NCH];

  reload_tmr_decode #(.NCH(NCH), .AW(AW)) u_wdec (
    .addr_i(wr_addr), .kind_o(w_kind), .ch_o(w_ch));
  reload_tmr_decode #(.NCH(NCH), .AW(AW)) u_rdec (
    .addr_i(rd_addr), .kind_o(r_kind), .ch_o(r_ch));

  assign ctl_wr = wr_en && (w_kind == RK_CTL);

  always_comb begin
    ctl_nxt = ctl_q;
    for (int n = 0; n < NCH; n++)
      if (stop_req[n]) ctl_nxt[start_pos(n)] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= wr_data;
    else             ctl_q <= ctl_nxt;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    reload_tmr_chan #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i[n]),
      .ctl_wr_i (ctl_wr),
      .man_old_i(ctl_q[man_pos(n)]),
      .man_new_i(wr_data[man_pos(n)]),
      .run_i    (ctl_q[start_pos(n)]),
      .ar_i     (ctl_q[reload_pos(n, NCH)]),
      .buf_wr_i (wr_en && w_kind == RK_BUF && w_ch == CHW'(n)),
      .cmp_wr_i (wr_en && w_kind == RK_CMP && w_ch == CHW'(n)),
      .wdata_i  (wr_data[CW-1:0]),
      .cnt_o    (cnt_a[n]),
      .buf_o    (buf_a[n]),
      .cmp_o    (cmp_a[n]),
      .expire_o (expire_o[n]),
      .stop_o   (stop_req[n])
    );

    // R8: a self-stop clears exactly this channel's start bit
    p_start_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_req[n]) |-> !ctl_q[start_pos(n)]);
  end

  always_comb begin
    rd_data = '0;
    unique case (r_kind)
      RK_CTL:  rd_data = ctl_q;
      RK_BUF:  rd_data = 32'(buf_a[r_ch]);
      RK_CMP:  rd_data = 32'(cmp_a[r_ch]);
      RK_OBS:  rd_data = 32'(cnt_a[r_ch]);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: tb/tb_reload_tmr_bank.sv
module tb_reload_tmr_bank;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_TK = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 60;
  localparam vec_t VEC [NV] = '{
    '{K_WR, 8'h0C, 32'd5,        32'd0,        4'd2},
    '{K_RD, 8'h0C, 32'd0,        32'd5,        4'd2},   // R2 buffer readback
    '{K_WR, 8'h10, 32'hABCD,     32'd0,        4'd2},
    '{K_RD, 8'h10, 32'd0,        32'hABCD,     4'd2},   // R2 compare readback
    '{K_WR, 8'h08, 32'h2,        32'd0,        4'd3},
    '{K_RD, 8'h14, 32'd0,        32'd5,        4'd3},   // R3 manual load
    '{K_TK, 8'h00, 32'h01,       32'd0,        4'd4},
    '{K_RD, 8'h14, 32'd0,        32'd5,        4'd4},   // R4 stopped ignores tick
    '{K_WR, 8'h08, 32'h3,        32'd0,        4'd4},
    '{K_TK, 8'h00, 32'h01,       32'd0,        4'd4},
    '{K_RD, 8'h14, 32'd0,        32'd4,        4'd4},   // R4 decrement
    '{K_WR, 8'h0C, 32'd9,        32'd0,        4'd3},
    '{K_WR, 8'h08, 32'h3,        32'd0,        4'd3},
    '{K_RD, 8'h14, 32'd0,        32'd4,        4'd3},   // R3 no edge, no load
    '{K_WR, 8'h08, 32'h2,        32'd0,        4'd5},
    '{K_TK, 8'h00, 32'h01,       32'd0,        4'd5},
    '{K_RD, 8'h14, 32'd0,        32'd4,        4'd5},   // R5 halted holds
    '{K_WR, 8'h08, 32'h3,        32'd0,        4'd6},
    '{K_TK, 8'h00, 32'h01,       32'd0,        4'd6},
    '{K_TK, 8'h00, 32'h01,       32'd0,        4'd6},
    '{K_TK, 8'h00, 32'h01,       32'd0,        4'd6},
    '{K_TK, 8'h00, 32'h01,       32'd0,        4'd6},
    '{K_TK, 8'h00, 32'h01,       32'h01,       4'd6},   // R6 expiry pulse
    '{K_RD, 8'h08, 32'd0,        32'h2,        4'd8},   // R8 start bit cleared
    '{K_RD, 8'h14, 32'd0,        32'd0,        4'd8},
    '{K_TK, 8'h00, 32'h01,       32'd0,        4'd8},   // R8 stays stopped
    '{K_WR, 8'h0C, 32'd2,        32'd0,        4'd7},
    '{K_WR, 8'h08, 32'h0,        32'd0,        4'd7},
    '{K_WR, 8'h08, 32'hB,        32'd0,        4'd7},
    '{K_TK, 8'h00, 32'h01,       32'd0,        4'd7},
    '{K_TK, 8'h00, 32'h01,       32'd0,        4'd7},
    '{K_TK, 8'h00, 32'h01,       32'h01,       4'd7},
    '{K_RD, 8'h14, 32'd0,        32'd2,        4'd7},   // R7 reloaded
    '{K_RD, 8'h08, 32'd0,        32'hB,        4'd7},   // R7 start kept
    '{K_TK, 8'h00, 32'h01,       32'd0,        4'd7},
    '{K_RD, 8'h14, 32'd0,        32'd1,        4'd7},   // R7 keeps running
    '{K_WR, 8'h3C, 32'd1,        32'd0,        4'd9},
    '{K_WR, 8'h08, 32'h00700000, 32'd0,        4'd9},
    '{K_TK, 8'h00, 32'h10,       32'd0,        4'd9},
    '{K_TK, 8'h00, 32'h10,       32'h10,       4'd9},   // R9 last channel expiry
    '{K_RD, 8'h40, 32'd0,        32'd1,        4'd9},   // R9 reload at bit 22
    '{K_RD, 8'h08, 32'd0,        32'h00700000, 4'd9},
    '{K_WR, 8'h08, 32'h0,        32'd0,        4'd9},
    '{K_WR, 8'h08, 32'h00300000, 32'd0,        4'd9},
    '{K_TK, 8'h00, 32'h10,       32'd0,        4'd9},
    '{K_TK, 8'h00, 32'h10,       32'h10,       4'd9},
    '{K_RD, 8'h08, 32'd0,        32'h00200000, 4'd9},   // R9 bit 20 cleared
    '{K_RD, 8'h40, 32'd0,        32'd0,        4'd9},
    '{K_WR, 8'h18, 32'd3,        32'd0,        4'd9},
    '{K_WR, 8'h08, 32'h300,      32'd0,        4'd9},
    '{K_TK, 8'h00, 32'h02,       32'd0,        4'd9},
    '{K_RD, 8'h20, 32'd0,        32'd2,        4'd9},   // R9 channel 1 base 8
    '{K_WR, 8'h48, 32'hFFFF,     32'd0,        4'd11},
    '{K_RD, 8'h48, 32'd0,        32'd0,        4'd11},  // R11 unmapped
    '{K_RD, 8'h00, 32'd0,        32'd0,        4'd11},
    '{K_RD, 8'h08, 32'd0,        32'h300,      4'd11},  // R11 control untouched
    '{K_WR, 8'h34, 32'h77,       32'd0,        4'd2},
    '{K_RD, 8'h34, 32'd0,        32'h77,       4'd2},   // R2 channel 3 compare
    '{K_RD, 8'h3C, 32'd0,        32'd1,        4'd2},   // R2 channel 4 buffer
    '{K_RD, 8'h0C, 32'd0,        32'd2,        4'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [4:0] tick_i = '0;
  logic [4:0] expire_o;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  reload_tmr_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_i(tick_i), .expire_o(expire_o));

  task automatic check(input logic [31:0] act, input logic [31:0] exp_v,
                       input int req);
    total++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [31:0] e, input int req);
    @(negedge clk);
    rd_addr = a;
    #1 check(rd_data, e, req);
  endtask

  task automatic do_tk(input logic [4:0] m, input logic [31:0] e, input int req);
    @(negedge clk);
    tick_i = m;
    @(negedge clk);
    tick_i = '0;
    check(32'(expire_o), e, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    check(32'(expire_o), 32'd0, 1);
    do_rd(8'h08, 32'd0, 1);
    do_rd(8'h0C, 32'd0, 1);
    do_rd(8'h14, 32'd0, 1);
    do_rd(8'h40, 32'd0, 1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        K_WR:    do_wr(VEC[i].addr, VEC[i].data);
        K_RD:    do_rd(VEC[i].addr, VEC[i].expv, int'(VEC[i].req));
        default: do_tk(VEC[i].data[4:0], VEC[i].expv, int'(VEC[i].req));
      endcase
    end

    // R10: channel 1 is running at 2; tick coincides with a control write
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h08; wr_data = 32'h300; tick_i = 5'h02;
    @(negedge clk);
    wr_en = 1'b0; tick_i = '0;
    check(32'(expire_o), 32'd0, 10);
    do_rd(8'h20, 32'd2, 10);
    do_tk(5'h02, 32'd0, 10);
    do_rd(8'h20, 32'd1, 10);   // R10 still running afterwards

    // R6: pulse lasts one cycle only
    do_tk(5'h02, 32'd0, 6);
    do_tk(5'h02, 32'h02, 6);
    @(negedge clk);
    check(32'(expire_o), 32'd0, 6);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule